// File: doc/BRIEF.md
# Mailbox interrupt status aggregator

This block collects the interrupt vectors produced by a bank of mailboxes and turns them around so that each interrupt channel sees one bit per mailbox. Every mailbox presents one raw bit and one masked bit per channel. The block transposes both into per-channel status words and ORs each masked word into one interrupt line per channel. It also offers a small read port from which software fetches the masked word for its channel, the raw word (for polled use) or a configuration word.

How many mailboxes and channels are live is set by two 6-bit count inputs, each 1 to 32. Mailboxes and channels at or beyond those counts are gated off. The configuration word also reports a 3-bit data-register count, taken from an input.

Top module: `mbx_irq_agg`

## Requirements
- R1: Mailbox m presents its masked bit for channel c at input index m*CHAN_MAX+c. A read with `rd_addr_i` = c (0..31) returns the masked word for channel c in the cycle after `rd_en_i` is high, with bit m equal to mailbox m's masked bit as sampled at that clock edge.
- R2: A read with `rd_addr_i` = 32+c returns the raw word for channel c, built the same way from `mbox_raw_i`.
- R3: `irq_o[c]` is the OR of all bits of channel c's masked word. It is registered, so it changes one clock edge after the inputs change and has no combinational path from them.
- R4: Bits for mailbox indices at or above `mbox_cnt_i` read as zero in both words and never raise an interrupt.
- R5: For channels at or above `chan_cnt_i`, `irq_o` stays low and both status words read as zero.
- R6: A read of address 64 returns the configuration word: `mbox_cnt_i` in bits [5:0], `chan_cnt_i` in bits [13:8], `data_cnt_i` in bits [18:16], and zero in every other bit.
- R7: Reads of addresses 65 to 127 return zero. `rd_data_o` is zero in any cycle that follows a cycle with `rd_en_i` low.
- R8: While `rst_n` is low, `irq_o` and `rd_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mbox_raw_i | input | MBOX_MAX*CHAN_MAX | Raw interrupt bits, mailbox-major |
| mbox_msk_i | input | MBOX_MAX*CHAN_MAX | Masked interrupt bits, mailbox-major |
| mbox_cnt_i | input | 6 | Number of live mailboxes, 1..32 |
| chan_cnt_i | input | 6 | Number of live channels, 1..32 |
| data_cnt_i | input | 3 | Data registers per mailbox, reported only |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 7 | Read word address |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | CHAN_MAX | Registered per-channel interrupt lines |

## Verification
The assertions assume that the count inputs stay within 1 to 32 and do not change while reset is released. They also assume that the inputs are stable around each clock edge, so that the registered interrupts and read data can be compared with the values the previous cycle presented. The bench keeps to this. It changes every input only on the falling edge, and it takes its counts from a table whose entries all lie inside the supported range, including the edge values 1, 31 and 32.

// File: rtl/mbx_agg_pkg.sv
package mbx_agg_pkg;
  localparam int CNT_W  = 6;
  localparam int DCNT_W = 3;
  localparam int RD_W   = 32;
  localparam int ADDR_W = 7;

  localparam logic [1:0] REGION_MSK = 2'd0;
  localparam logic [1:0] REGION_RAW = 2'd1;
  localparam logic [1:0] REGION_CFG = 2'd2;

  // index idx is live when it lies below the count
  function automatic logic is_live(logic [CNT_W-1:0] cnt, int unsigned idx);
    return 32'(cnt) > idx;
  endfunction

  function automatic logic [RD_W-1:0] cfg_word(logic [CNT_W-1:0] mcnt,
                                               logic [CNT_W-1:0] ccnt,
                                               logic [DCNT_W-1:0] dcnt);
    logic [RD_W-1:0] w;
    w        = '0;
    w[5:0]   = mcnt;
    w[13:8]  = ccnt;
    w[18:16] = dcnt;
    return w;
  endfunction
endpackage

// File: rtl/mbx_act_mask.sv
module mbx_act_mask
  import mbx_agg_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [N-1:0]     live_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign live_o[i] = is_live(cnt_i, i);
  end
endmodule

// File: rtl/mbx_status_xpose.sv
module mbx_status_xpose #(
  parameter int MBOX_MAX = 32,
  parameter int CHAN_MAX = 32
) (
  input  logic [MBOX_MAX*CHAN_MAX-1:0]        vec_i,
  input  logic [MBOX_MAX-1:0]                 mbox_live_i,
  input  logic [CHAN_MAX-1:0]                 chan_live_i,
  output logic [CHAN_MAX-1:0][MBOX_MAX-1:0]   word_o
);
  for (genvar c = 0; c < CHAN_MAX; c++) begin : g_chan
    for (genvar m = 0; m < MBOX_MAX; m++) begin : g_mbox
      assign word_o[c][m] = vec_i[m*CHAN_MAX+c] & mbox_live_i[m] & chan_live_i[c];
    end
  end
endmodule

// File: rtl/mbx_irq_reduce.sv
module mbx_irq_reduce #(
  parameter int MBOX_MAX = 32,
  parameter int CHAN_MAX = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CHAN_MAX-1:0][MBOX_MAX-1:0] word_i,
  output logic [CHAN_MAX-1:0]               irq_o
);
  logic [CHAN_MAX-1:0] any_hit;

  for (genvar c = 0; c < CHAN_MAX; c++) begin : g_or
    assign any_hit[c] = |word_i[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= any_hit;
  end

  // R8: lines are quiet in reset
  a_r8_irq_reset: assert property (@(posedge clk) !rst_n |-> irq_o == '0);
endmodule

// File: rtl/mbx_stat_rdport.sv
module mbx_stat_rdport
  import mbx_agg_pkg::*;
#(
  parameter int MBOX_MAX = 32,
  parameter int CHAN_MAX = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  input  logic [CHAN_MAX-1:0][MBOX_MAX-1:0] msk_words_i,
  input  logic [CHAN_MAX-1:0][MBOX_MAX-1:0] raw_words_i,
  input  logic [RD_W-1:0]                   cfg_i,
  output logic [RD_W-1:0]                   rd_data_o
);
  logic [1:0]          region;
  logic [4:0]          idx;
  logic [MBOX_MAX-1:0] msk_sel;
  logic [MBOX_MAX-1:0] raw_sel;
  logic [RD_W-1:0]     rd_next;
  logic                past_ok;
  logic                cfg_hit;

  assign region  = rd_addr_i[6:5];
  assign idx     = rd_addr_i[4:0];
  assign cfg_hit = (region == REGION_CFG) && (idx == 5'd0);

  always_comb begin
    msk_sel = '0;
    raw_sel = '0;
    for (int c = 0; c < CHAN_MAX; c++) begin
      if (idx == 5'(c)) begin
        msk_sel = msk_words_i[c];
        raw_sel = raw_words_i[c];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (region == REGION_MSK)      rd_next = RD_W'(msk_sel);
    else if (region == REGION_RAW) rd_next = RD_W'(raw_sel);
    else if (cfg_hit)              rd_next = cfg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o <= '0;
      past_ok   <= 1'b0;
    end else begin
      rd_data_o <= rd_en_i ? rd_next : '0;
      past_ok   <= 1'b1;
    end
  end

  // R7: no strobe, no data
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$past(rd_en_i) |-> rd_data_o == '0);
  // R6: reserved configuration bits stay clear
  a_r6_cfg_reserved: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(rd_en_i && cfg_hit) |-> (rd_data_o[31:19] == '0 && rd_data_o[15:14] == '0
                                   && rd_data_o[7:6] == '0));
  // R8: data bus quiet in reset
  a_r8_rd_reset: assert property (@(posedge clk) !rst_n |-> rd_data_o == '0);
endmodule

// File: rtl/mbx_irq_agg.sv
module mbx_irq_agg
  import mbx_agg_pkg::*;
#(
  parameter int MBOX_MAX = 32,
  parameter int CHAN_MAX = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [MBOX_MAX*CHAN_MAX-1:0] mbox_raw_i,
  input  logic [MBOX_MAX*CHAN_MAX-1:0] mbox_msk_i,
  input  logic [CNT_W-1:0]             mbox_cnt_i,
  input  logic [CNT_W-1:0]             chan_cnt_i,
  input  logic [DCNT_W-1:0]            data_cnt_i,
  input  logic                         rd_en_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [RD_W-1:0]              rd_data_o,
  output logic [CHAN_MAX-1:0]          irq_o
);
  logic [MBOX_MAX-1:0]               mbox_live;
  logic [CHAN_MAX-1:0]               chan_live;
  logic [CHAN_MAX-1:0][MBOX_MAX-1:0] msk_words;
  logic [CHAN_MAX-1:0][MBOX_MAX-1:0] raw_words;
  logic [RD_W-1:0]                   cfg_w;
  logic                              past_ok;

  assign cfg_w = cfg_word(mbox_cnt_i, chan_cnt_i, data_cnt_i);

  mbx_act_mask #(.N(MBOX_MAX)) u_mbox_live (.cnt_i(mbox_cnt_i), .live_o(mbox_live));
  mbx_act_mask #(.N(CHAN_MAX)) u_chan_live (.cnt_i(chan_cnt_i), .live_o(chan_live));

  mbx_status_xpose #(.MBOX_MAX(MBOX_MAX), .CHAN_MAX(CHAN_MAX)) u_xp_msk (
    .vec_i(mbox_msk_i), .mbox_live_i(mbox_live), .chan_live_i(chan_live), .word_o(msk_words));
  mbx_status_xpose #(.MBOX_MAX(MBOX_MAX), .CHAN_MAX(CHAN_MAX)) u_xp_raw (
    .vec_i(mbox_raw_i), .mbox_live_i(mbox_live), .chan_live_i(chan_live), .word_o(raw_words));

  mbx_irq_reduce #(.MBOX_MAX(MBOX_MAX), .CHAN_MAX(CHAN_MAX)) u_reduce (
    .clk(clk), .rst_n(rst_n), .word_i(msk_words), .irq_o(irq_o));

  mbx_stat_rdport #(.MBOX_MAX(MBOX_MAX), .CHAN_MAX(CHAN_MAX)) u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .msk_words_i(msk_words), .raw_words_i(raw_words), .cfg_i(cfg_w), .rd_data_o(rd_data_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R5: dead channels never fire
  a_r5_dead_chan_low: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (irq_o & ~$past(chan_live)) == '0);

  for (genvar c = 0; c < CHAN_MAX; c++) begin : g_chk
    // R3: each line follows its masked word one edge later
    a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      irq_o[c] == $past(msk_words[c] != '0));
    // R4: dead mailboxes contribute nothing to either word
    a_r4_dead_mbox_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((msk_words[c] | raw_words[c]) & ~mbox_live) == '0);
  end
endmodule

// File: tb/mbx_irq_agg_tb.sv
module mbx_irq_agg_tb;
  localparam int MB = 32;
  localparam int CH = 32;

  typedef struct packed {
    logic [1:0]  kind;   // 0 all zero, 1 all ones, 2 hashed
    logic [31:0] seed;
    logic [5:0]  mcnt;
    logic [5:0]  ccnt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 32'h0000_0000, 6'd32, 6'd32},
    '{2'd0, 32'h0000_0000, 6'd32, 6'd32},
    '{2'd2, 32'h1234_5678, 6'd32, 6'd32},
    '{2'd2, 32'hCAFE_0001, 6'd1,  6'd32},
    '{2'd1, 32'h0000_0000, 6'd31, 6'd31},
    '{2'd2, 32'h0BAD_F00D, 6'd17, 6'd5},
    '{2'd2, 32'h7777_1111, 6'd32, 6'd1},
    '{2'd1, 32'h0000_0000, 6'd3,  6'd29}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic [MB*CH-1:0] raw_in = '0;
  logic [MB*CH-1:0] msk_in = '0;
  logic [5:0] mcnt = 6'd32, ccnt = 6'd32;
  logic [2:0] dcnt = 3'd5;
  logic rd_en = 0;
  logic [6:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [CH-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] got;

  always #2 clk = ~clk;

  mbx_irq_agg #(.MBOX_MAX(MB), .CHAN_MAX(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .mbox_raw_i(raw_in), .mbox_msk_i(msk_in),
    .mbox_cnt_i(mcnt), .chan_cnt_i(ccnt), .data_cnt_i(dcnt),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq));

  function automatic logic hbit(logic [31:0] s, int m, int c, int salt);
    logic [31:0] x;
    x = s ^ (m * 32'h9E3779B1) ^ (c * 32'h85EBCA77) ^ (salt * 32'h27D4EB2F);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x[7];
  endfunction

  // expected word for channel c from the bench's own copy of the inputs
  function automatic logic [31:0] exp_word(logic [MB*CH-1:0] v, int c);
    logic [31:0] w = '0;
    if (c < int'(ccnt))
      for (int m = 0; m < MB; m++)
        if (m < int'(mcnt)) w[m] = v[m*CH+c];
    return w;
  endfunction

  function automatic logic [CH-1:0] exp_irq();
    logic [CH-1:0] r = '0;
    for (int c = 0; c < CH; c++) r[c] = (exp_word(msk_in, c) != 0);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [6:0] a);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    got = rd_data;
    rd_en = 0;
  endtask

  task automatic load_vec(vec_t v);
    @(negedge clk);
    mcnt = v.mcnt; ccnt = v.ccnt;
    for (int m = 0; m < MB; m++)
      for (int c = 0; c < CH; c++) begin
        logic r, k;
        r = (v.kind == 2'd1) ? 1'b1 : (v.kind == 2'd0) ? 1'b0 : hbit(v.seed, m, c, 1);
        k = (v.kind == 2'd1) ? 1'b1 : hbit(v.seed, m, c, 2);
        raw_in[m*CH+c] = r;
        msk_in[m*CH+c] = r & k;
      end
  endtask

  task automatic single_bit(int m, int c, logic [5:0] mc, logic [5:0] cc);
    @(negedge clk);
    raw_in = '0; msk_in = '0;
    raw_in[m*CH+c] = 1'b1; msk_in[m*CH+c] = 1'b1;
    mcnt = mc; ccnt = cc;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R8: reset holds outputs quiet even with everything asserted
    raw_in = '1; msk_in = '1; rd_en = 1; rd_addr = 7'd0;
    repeat (3) @(negedge clk);
    check("R8 irq in reset", 32'(irq), 32'h0);
    check("R8 rd_data in reset", rd_data, 32'h0);
    rd_en = 0;
    rst_n = 1;

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      load_vec(VECS[i]);
      @(negedge clk);
      check("R3/R4/R5 irq vector", 32'(irq), 32'(exp_irq()));
      for (int c = 0; c < CH; c++) begin
        do_read(7'(c));
        check("R1/R4/R5 masked word", got, exp_word(msk_in, c));
        do_read(7'(32 + c));
        check("R2/R4/R5 raw word", got, exp_word(raw_in, c));
      end
    end

    // R3 latency: no change before the edge, change right after it
    single_bit(0, 0, 6'd32, 6'd32);
    @(negedge clk);
    single_bit(31, 31, 6'd32, 6'd32);
    #1;
    check("R3 before edge", 32'(irq), 32'h0000_0001);
    @(negedge clk);
    check("R3 after edge", 32'(irq), 32'h8000_0000);
    do_read(7'd31);
    check("R1 top corner masked", got, 32'h8000_0000);

    // R4 boundary: mailbox 31 with 31 live mailboxes
    single_bit(31, 4, 6'd31, 6'd32);
    @(negedge clk);
    check("R4 irq mbox at count", 32'(irq), 32'h0);
    do_read(7'd4);
    check("R4 masked mbox at count", got, 32'h0);
    do_read(7'd36);
    check("R4 raw mbox at count", got, 32'h0);

    // R4 lower edge: one live mailbox, mailbox 0 counts
    single_bit(0, 9, 6'd1, 6'd32);
    @(negedge clk);
    check("R4 single mailbox live", 32'(irq), 32'h0000_0200);

    // R5 boundary: channel 31 with 31 live channels
    single_bit(2, 31, 6'd32, 6'd31);
    @(negedge clk);
    check("R5 irq chan at count", 32'(irq), 32'h0);
    do_read(7'd63);
    check("R5 raw chan at count", got, 32'h0);

    // R6 configuration word
    mcnt = 6'd17; ccnt = 6'd9; dcnt = 3'd7;
    do_read(7'd64);
    check("R6 config word", got, 32'h0007_0911);
    mcnt = 6'd32; ccnt = 6'd1; dcnt = 3'd0;
    do_read(7'd64);
    check("R6 config word edges", got, 32'h0000_0120);

    // R7 unmapped addresses and idle cycles
    raw_in = '1; msk_in = '1; mcnt = 6'd32; ccnt = 6'd32;
    do_read(7'd65);
    check("R7 addr 65", got, 32'h0);
    do_read(7'd96);
    check("R7 addr 96", got, 32'h0);
    do_read(7'd127);
    check("R7 addr 127", got, 32'h0);
    do_read(7'd0);
    check("R1 all ones masked", got, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R7 idle after read", rd_data, 32'h0);

    // R8 reset re-entry
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R8 irq async reset", 32'(irq), 32'h0);
    @(negedge clk);
    rst_n = 1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule